// File: doc/BRIEF.md
# Bank-Interleaved Register File with Two Write Ports

This block is a 64-entry, 64-bit register file that accepts two writes per clock without a memory that has two write ports. The registers are spread across four single-write banks of sixteen entries. The two least significant bits of a register number pick its bank, and the remaining four bits pick the row inside that bank. Writes that land in different banks both complete on the same edge. This covers the common case of an instruction that returns two results, such as a load that also updates its address register, whose results may arrive in the same cycle or in different cycles.

When both ports hit the same bank in one cycle, port 0 is written at once. Port 1 is parked in a one-entry holding register. That entry drains into its bank on the first cycle in which port 0 leaves the bank alone. While the entry is occupied, a busy flag tells the issuing logic to hold back any further port-1 write. Read ports are registered: each one takes a full cycle and looks into the holding register, so a parked value is never hidden behind stale bank contents.

Top module: `rf_dual_write`

## Requirements
- R1: After reset, every register reads as zero, every read output is zero and `wr1_busy` is low.
- R2: Two writes in one cycle whose register numbers differ in bits [1:0] both take effect at that edge, and `wr1_busy` stays low afterwards.
- R3: Two writes in one cycle to different registers whose numbers share bits [1:0] store the port-0 value at once and park the port-1 value. `wr1_busy` is high from the following cycle on.
- R4: A parked value is written into its bank at the first edge where port 0 does not write that bank. `wr1_busy` is low after that edge, and while port 0 keeps writing other rows of the same bank, `wr1_busy` stays high.
- R5: A read address presented at an edge returns, in the following cycle, the register value set by all writes accepted at earlier edges, including a value that is still parked. Writes at the same edge are not visible.
- R6: When both ports write the same register in one cycle, the port-1 data is kept, the port-0 data is discarded and `wr1_busy` is not raised.
- R7: A port-0 write to the register that is currently parked replaces the parked value and releases the holding register, so `wr1_busy` is low after that edge.
- R8: The issuer does not assert `wr1_en` while `wr1_busy` is high.
- R9: All read ports work independently and at the same time, on any mix of addresses and any banks.
- R10: A port whose enable is low changes no register, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr0_en | input | 1 | Port-0 write enable |
| wr0_addr | input | 6 | Port-0 register number |
| wr0_data | input | 64 | Port-0 write data |
| wr1_en | input | 1 | Port-1 write enable |
| wr1_addr | input | 6 | Port-1 register number |
| wr1_data | input | 64 | Port-1 write data |
| rd_addr | input | 12 | Read register numbers, port p in bits [6p+5:6p] |
| rd_data | output | 128 | Registered read data, port p in bits [64p+63:64p] |
| wr1_busy | output | 1 | Holding register occupied; do not issue on port 1 |

## Verification
The properties assume that the issuer obeys the busy flag: port 1 is idle in every cycle in which `wr1_busy` is high. The drain property also relies on that, because it treats a busy cycle with port 0 away from the parked bank as free of any new conflict. The bench keeps its stimulus inside this contract: its reference model tracks whether a parked write is pending, and every directed or random step forces `wr1_en` low while one is. Both write ports otherwise take any address, so same-bank, same-register and kill cases all occur.

// File: rtl/rf_dw_pkg.sv
package rf_dw_pkg;

   // Which source drives one bank's write port in a given cycle.
   typedef enum logic [1:0] {
      WSRC_NONE = 2'd0,
      WSRC_P0   = 2'd1,
      WSRC_P1   = 2'd2,
      WSRC_HOLD = 2'd3
   } wsrc_e;

endpackage

// File: rtl/rf_dw_bank.sv
module rf_dw_bank #(
   parameter int DATA_W         = 64,
   parameter int DEPTH          = 16,
   parameter int NUM_RD         = 2,
   parameter bit RESET_CONTENTS = 1'b1,
   localparam int IDX_W         = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [IDX_W-1:0]         widx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_RD*IDX_W-1:0]  ridx,
   output logic [NUM_RD*DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (RESET_CONTENTS) begin : g_rst_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[widx] <= wdata;
            end
         end
      end else begin : g_plain_store
         always_ff @(posedge clk) begin
            if (we) mem[widx] <= wdata;
         end
      end
   endgenerate

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         assign rdata[p*DATA_W +: DATA_W] = mem[ridx[p*IDX_W +: IDX_W]];
      end
   endgenerate

endmodule

// File: rtl/rf_dw_hold.sv
module rf_dw_hold #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         addr  <= '0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         addr  <= in_addr;
         data  <= in_data;
      end else if (clear) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/rf_dw_steer.sv
module rf_dw_steer
   import rf_dw_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int NUM_BANKS = 4,
   parameter int IDX_W     = 4,
   localparam int BANK_BITS = $clog2(NUM_BANKS),
   localparam int ADDR_W    = BANK_BITS + IDX_W
) (
   input  logic                          wr0_en,
   input  logic [ADDR_W-1:0]             wr0_addr,
   input  logic [DATA_W-1:0]             wr0_data,
   input  logic                          wr1_en,
   input  logic [ADDR_W-1:0]             wr1_addr,
   input  logic [DATA_W-1:0]             wr1_data,
   input  logic                          hold_valid,
   input  logic [ADDR_W-1:0]             hold_addr,
   input  logic [DATA_W-1:0]             hold_data,
   output logic [NUM_BANKS-1:0]          bank_we,
   output logic [NUM_BANKS*IDX_W-1:0]    bank_widx,
   output logic [NUM_BANKS*DATA_W-1:0]   bank_wdata,
   output logic                          hold_load,
   output logic                          hold_clear
);

   logic                 same_reg;
   logic                 p0_live;
   logic                 p1_defer;
   logic                 p1_live;
   logic                 hold_kill;
   logic                 hold_drain;
   logic [BANK_BITS-1:0] bank0;
   logic [BANK_BITS-1:0] bank1;
   logic [BANK_BITS-1:0] bankh;

   assign bank0 = wr0_addr[BANK_BITS-1:0];
   assign bank1 = wr1_addr[BANK_BITS-1:0];
   assign bankh = hold_addr[BANK_BITS-1:0];

   always_comb begin
      // Same register on both ports: port 1 is the survivor.
      same_reg   = wr0_en && wr1_en && (wr0_addr == wr1_addr);
      p0_live    = wr0_en && !same_reg;
      p1_defer   = wr1_en && p0_live && (bank0 == bank1);
      p1_live    = wr1_en && !p1_defer;
      // A newer write to the parked register makes the parked value obsolete.
      hold_kill  = hold_valid &&
                   ((p0_live && (wr0_addr == hold_addr)) ||
                    (p1_live && (wr1_addr == hold_addr)));
      hold_drain = hold_valid && !hold_kill &&
                   !(p0_live && (bank0 == bankh)) &&
                   !(p1_live && (bank1 == bankh));
      hold_load  = p1_defer;
      hold_clear = hold_kill || hold_drain;
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [BANK_BITS-1:0] BID = BANK_BITS'(b);
         wsrc_e src;

         always_comb begin
            if (p0_live && (bank0 == BID))
               src = WSRC_P0;
            else if (p1_live && (bank1 == BID))
               src = WSRC_P1;
            else if (hold_drain && (bankh == BID))
               src = WSRC_HOLD;
            else
               src = WSRC_NONE;
         end

         always_comb begin
            bank_we[b]                        = 1'b0;
            bank_widx[b*IDX_W +: IDX_W]       = '0;
            bank_wdata[b*DATA_W +: DATA_W]    = '0;
            case (src)
               WSRC_P0: begin
                  bank_we[b]                     = 1'b1;
                  bank_widx[b*IDX_W +: IDX_W]    = wr0_addr[ADDR_W-1:BANK_BITS];
                  bank_wdata[b*DATA_W +: DATA_W] = wr0_data;
               end
               WSRC_P1: begin
                  bank_we[b]                     = 1'b1;
                  bank_widx[b*IDX_W +: IDX_W]    = wr1_addr[ADDR_W-1:BANK_BITS];
                  bank_wdata[b*DATA_W +: DATA_W] = wr1_data;
               end
               WSRC_HOLD: begin
                  bank_we[b]                     = 1'b1;
                  bank_widx[b*IDX_W +: IDX_W]    = hold_addr[ADDR_W-1:BANK_BITS];
                  bank_wdata[b*DATA_W +: DATA_W] = hold_data;
               end
               default: ;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/rf_dw_rdport.sv
module rf_dw_rdport #(
   parameter int DATA_W    = 64,
   parameter int NUM_BANKS = 4,
   parameter int IDX_W     = 4,
   localparam int BANK_BITS = $clog2(NUM_BANKS),
   localparam int ADDR_W    = BANK_BITS + IDX_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
   input  logic                        hold_valid,
   input  logic [ADDR_W-1:0]           hold_addr,
   input  logic [DATA_W-1:0]           hold_data,
   output logic [DATA_W-1:0]           rdata_q
);

   logic [DATA_W-1:0] from_bank;
   logic [DATA_W-1:0] rdata_d;
   logic              hold_hit;

   always_comb begin
      from_bank = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr[BANK_BITS-1:0] == BANK_BITS'(b))
            from_bank = bank_rdata[b*DATA_W +: DATA_W];
      end
      hold_hit = hold_valid && (hold_addr == addr);
      rdata_d  = hold_hit ? hold_data : from_bank;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rdata_d;
   end

endmodule

// File: rtl/rf_dual_write.sv
module rf_dual_write #(
   parameter int DATA_W         = 64,
   parameter int NUM_BANKS      = 4,
   parameter int BANK_DEPTH     = 16,
   parameter int NUM_RD         = 2,
   parameter bit RESET_CONTENTS = 1'b1,
   localparam int BANK_BITS     = $clog2(NUM_BANKS),
   localparam int IDX_W         = $clog2(BANK_DEPTH),
   localparam int ADDR_W        = BANK_BITS + IDX_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr0_en,
   input  logic [ADDR_W-1:0]        wr0_addr,
   input  logic [DATA_W-1:0]        wr0_data,
   input  logic                     wr1_en,
   input  logic [ADDR_W-1:0]        wr1_addr,
   input  logic [DATA_W-1:0]        wr1_data,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   output logic [NUM_RD*DATA_W-1:0] rd_data,
   output logic                     wr1_busy
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (BANK_DEPTH < 2 || (BANK_DEPTH & (BANK_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("BANK_DEPTH must be a power of two of at least 2");
      end
      if (NUM_RD < 1) begin : g_bad_rd
         $error("NUM_RD must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic [NUM_BANKS-1:0]        bank_we;
   logic [NUM_BANKS*IDX_W-1:0]  bank_widx;
   logic [NUM_BANKS*DATA_W-1:0] bank_wdata;
   logic                        hold_load;
   logic                        hold_clear;
   logic                        hold_valid;
   logic [ADDR_W-1:0]           hold_addr;
   logic [DATA_W-1:0]           hold_data;
   logic [NUM_RD*IDX_W-1:0]     rd_idx;
   logic [NUM_RD*DATA_W-1:0]    bank_rd [NUM_BANKS];
   logic [NUM_BANKS*DATA_W-1:0] port_rd [NUM_RD];

   rf_dw_steer #(
      .DATA_W    (DATA_W),
      .NUM_BANKS (NUM_BANKS),
      .IDX_W     (IDX_W)
   ) u_steer (
      .wr0_en     (wr0_en),
      .wr0_addr   (wr0_addr),
      .wr0_data   (wr0_data),
      .wr1_en     (wr1_en),
      .wr1_addr   (wr1_addr),
      .wr1_data   (wr1_data),
      .hold_valid (hold_valid),
      .hold_addr  (hold_addr),
      .hold_data  (hold_data),
      .bank_we    (bank_we),
      .bank_widx  (bank_widx),
      .bank_wdata (bank_wdata),
      .hold_load  (hold_load),
      .hold_clear (hold_clear)
   );

   rf_dw_hold #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (hold_load),
      .clear   (hold_clear),
      .in_addr (wr1_addr),
      .in_data (wr1_data),
      .valid   (hold_valid),
      .addr    (hold_addr),
      .data    (hold_data)
   );

   assign wr1_busy = hold_valid;

   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_idx
         assign rd_idx[p*IDX_W +: IDX_W] = rd_addr[p*ADDR_W + BANK_BITS +: IDX_W];
      end

      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_banks
         rf_dw_bank #(
            .DATA_W         (DATA_W),
            .DEPTH          (BANK_DEPTH),
            .NUM_RD         (NUM_RD),
            .RESET_CONTENTS (RESET_CONTENTS)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .widx  (bank_widx[b*IDX_W +: IDX_W]),
            .wdata (bank_wdata[b*DATA_W +: DATA_W]),
            .ridx  (rd_idx),
            .rdata (bank_rd[b])
         );
      end

      for (genvar p = 0; p < NUM_RD; p++) begin : g_ports
         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gather
            assign port_rd[p][b*DATA_W +: DATA_W] = bank_rd[b][p*DATA_W +: DATA_W];
         end

         rf_dw_rdport #(
            .DATA_W    (DATA_W),
            .NUM_BANKS (NUM_BANKS),
            .IDX_W     (IDX_W)
         ) u_rdport (
            .clk        (clk),
            .rst_n      (rst_n),
            .addr       (rd_addr[p*ADDR_W +: ADDR_W]),
            .bank_rdata (port_rd[p]),
            .hold_valid (hold_valid),
            .hold_addr  (hold_addr),
            .hold_data  (hold_data),
            .rdata_q    (rd_data[p*DATA_W +: DATA_W])
         );
      end
   endgenerate

endmodule

// File: rtl/rf_dual_write_chk.sv
module rf_dual_write_chk #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 6,
   parameter int BANK_BITS = 2,
   parameter int NUM_RD = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr0_en,
   input logic [ADDR_W-1:0]        wr0_addr,
   input logic                     wr1_en,
   input logic [ADDR_W-1:0]        wr1_addr,
   input logic                     wr1_busy,
   input logic [ADDR_W-1:0]        hold_addr,
   input logic [DATA_W-1:0]        hold_data,
   input logic [NUM_RD*ADDR_W-1:0] rd_addr,
   input logic [NUM_RD*DATA_W-1:0] rd_data
);

   // R8: the issuer keeps port 1 idle while the holding register is occupied.
   a_r8_no_wr1_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wr1_busy |-> !wr1_en);

   // R3: a same-bank pair of distinct registers raises busy on the next cycle.
   a_r3_busy_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr1_busy && wr0_en && wr1_en &&
       (wr0_addr[BANK_BITS-1:0] == wr1_addr[BANK_BITS-1:0]) &&
       (wr0_addr != wr1_addr)) |=> wr1_busy);

   // R2: a port-1 write with no bank clash leaves busy low.
   a_r2_no_busy_diff_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr1_busy && wr1_en &&
       (!wr0_en || (wr0_addr[BANK_BITS-1:0] != wr1_addr[BANK_BITS-1:0])))
      |=> !wr1_busy);

   // R6: identical registers on both ports never park anything.
   a_r6_same_reg_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr1_busy && wr0_en && wr1_en && (wr0_addr == wr1_addr)) |=> !wr1_busy);

   // R4: the parked entry drains as soon as port 0 leaves its bank alone.
   a_r4_drain_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1_busy && !(wr0_en && (wr0_addr[BANK_BITS-1:0] == hold_addr[BANK_BITS-1:0])))
      |=> !wr1_busy);

   // R4: port 0 writing another row of the parked bank keeps the entry waiting.
   a_r4_wait_on_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1_busy && wr0_en && (wr0_addr != hold_addr) &&
       (wr0_addr[BANK_BITS-1:0] == hold_addr[BANK_BITS-1:0])) |=> wr1_busy);

   // R7: a port-0 write to the parked register releases the entry.
   a_r7_kill_on_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1_busy && wr0_en && (wr0_addr == hold_addr)) |=> !wr1_busy);

   // R5: reading the parked register returns the parked data.
   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_byp
         a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            (wr1_busy && (rd_addr[p*ADDR_W +: ADDR_W] == hold_addr))
            |=> (rd_data[p*DATA_W +: DATA_W] == $past(hold_data)));
      end
   endgenerate

endmodule

bind rf_dual_write rf_dual_write_chk #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .BANK_BITS (BANK_BITS),
   .NUM_RD    (NUM_RD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr0_en    (wr0_en),
   .wr0_addr  (wr0_addr),
   .wr1_en    (wr1_en),
   .wr1_addr  (wr1_addr),
   .wr1_busy  (wr1_busy),
   .hold_addr (hold_addr),
   .hold_data (hold_data),
   .rd_addr   (rd_addr),
   .rd_data   (rd_data)
);

// File: tb/rf_dual_write_tb.sv
module rf_dual_write_tb;

   localparam int DW = 64;
   localparam int AW = 6;
   localparam int NR = 2;
   localparam int NREG = 64;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           wr0_en, wr1_en;
   logic [AW-1:0]  wr0_addr, wr1_addr;
   logic [DW-1:0]  wr0_data, wr1_data;
   logic [NR*AW-1:0] rd_addr;
   logic [NR*DW-1:0] rd_data;
   logic           wr1_busy;

   always #5 clk = ~clk;

   rf_dual_write u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr0_en   (wr0_en),
      .wr0_addr (wr0_addr),
      .wr0_data (wr0_data),
      .wr1_en   (wr1_en),
      .wr1_addr (wr1_addr),
      .wr1_data (wr1_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .wr1_busy (wr1_busy)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model: architectural register values and a pending flag.
   logic [DW-1:0] arch [NREG];
   bit            pend;
   logic [AW-1:0] pend_a;
   logic [DW-1:0] exp_rd [NR];

   task automatic check(input string tag, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag,
                       input bit e0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input bit e1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                       input logic [AW-1:0] r0, input logic [AW-1:0] r1);
      wr0_en = e0; wr0_addr = a0; wr0_data = d0;
      wr1_en = e1; wr1_addr = a1; wr1_data = d1;
      rd_addr = {r1, r0};
      @(posedge clk);
      exp_rd[0] = arch[r0];
      exp_rd[1] = arch[r1];
      if (pend) begin
         if (e0 && a0 == pend_a) pend = 1'b0;
         else if (!(e0 && a0[1:0] == pend_a[1:0])) pend = 1'b0;
      end else if (e0 && e1 && a0[1:0] == a1[1:0] && a0 != a1) begin
         pend = 1'b1;
         pend_a = a1;
      end
      if (e0) arch[a0] = d0;
      if (e1) arch[a1] = d1;
      @(negedge clk);
      for (int p = 0; p < NR; p++)
         check(tag, $sformatf("rd%0d", p), rd_data[p*DW +: DW], exp_rd[p]);
      check(tag, "busy", {63'd0, wr1_busy}, {63'd0, pend});
   endtask

   task automatic rd2(input string tag, input logic [AW-1:0] r0, input logic [AW-1:0] r1);
      step(tag, 1'b0, 6'd0, 64'd0, 1'b0, 6'd0, 64'd0, r0, r1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NREG; i++) arch[i] = '0;
      pend = 1'b0; pend_a = '0;
      rst_n = 1'b0;
      wr0_en = 1'b0; wr1_en = 1'b0;
      wr0_addr = '0; wr1_addr = '0; wr0_data = '0; wr1_data = '0; rd_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", "rd_data", rd_data[DW-1:0], '0);
      check("R1", "busy", {63'd0, wr1_busy}, '0);
      rd2("R1", 6'd0, 6'd63);
      rd2("R1", 6'd22, 6'd41);

      // R2: different banks (5 -> bank 1, 10 -> bank 2) both land at once
      step("R2", 1'b1, 6'd5, 64'h1111_0005, 1'b1, 6'd10, 64'h2222_000a, 6'd5, 6'd10);
      rd2("R2", 6'd5, 6'd10);

      // R3/R5: collision in bank 0 (4, 8); read both while the entry drains
      step("R3", 1'b1, 6'd4, 64'hA0A0_0004, 1'b1, 6'd8, 64'hB0B0_0008, 6'd4, 6'd8);
      rd2("R5", 6'd8, 6'd4);
      rd2("R3", 6'd8, 6'd4);

      // R4: collision in bank 1 (1, 13), port 0 keeps bank 1 busy twice
      step("R4", 1'b1, 6'd1, 64'hC1C1_0001, 1'b1, 6'd13, 64'hD1D1_000d, 6'd13, 6'd1);
      step("R4", 1'b1, 6'd17, 64'hE1E1_0011, 1'b0, 6'd0, 64'd0, 6'd13, 6'd17);
      step("R4", 1'b1, 6'd21, 64'hF1F1_0015, 1'b0, 6'd0, 64'd0, 6'd13, 6'd17);
      step("R4", 1'b1, 6'd2, 64'h0202_0002, 1'b0, 6'd0, 64'd0, 6'd13, 6'd21);
      rd2("R4", 6'd13, 6'd2);

      // R7: park 7, then port 0 overwrites 7
      step("R7", 1'b1, 6'd3, 64'h3333_0003, 1'b1, 6'd7, 64'h7777_0007, 6'd3, 6'd7);
      step("R7", 1'b1, 6'd7, 64'h7E7E_0007, 1'b0, 6'd0, 64'd0, 6'd7, 6'd3);
      rd2("R7", 6'd7, 6'd3);
      rd2("R7", 6'd7, 6'd7);

      // R6: both ports write register 30, port 1 wins
      step("R6", 1'b1, 6'd30, 64'h0000_dead, 1'b1, 6'd30, 64'h0000_beef, 6'd30, 6'd0);
      rd2("R6", 6'd30, 6'd30);

      // R10: disabled ports carry noise but change nothing
      step("R10", 1'b0, 6'd30, 64'hFFFF_FFFF, 1'b0, 6'd5, 64'hEEEE_EEEE, 6'd30, 6'd5);
      rd2("R10", 6'd30, 6'd5);

      // R9: random mixed traffic, port 1 held back while a write is parked
      for (int i = 0; i < 2000; i++) begin
         bit e0, e1;
         logic [AW-1:0] a0, a1;
         e0 = ($urandom_range(0, 3) != 0);
         e1 = !pend && ($urandom_range(0, 2) != 0);
         a0 = AW'($urandom_range(0, NREG - 1));
         a1 = ($urandom_range(0, 7) == 0) ? a0 : AW'($urandom_range(0, NREG - 1));
         step("R9", e0, a0, {$urandom, $urandom}, e1, a1, {$urandom, $urandom},
              AW'($urandom_range(0, NREG - 1)),
              (pend && $urandom_range(0, 1) == 1) ? pend_a : AW'($urandom_range(0, NREG - 1)));
      end

      // R5: final sweep of every register
      for (int r = 0; r < NREG; r += 2) rd2("R5", AW'(r), AW'(r + 1));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule